// File: doc/BRIEF.md
# Rotate-and-Mask Unit

This unit rotates a 64-bit operand to the left and then clears every bit outside a window chosen by two bit indices. Bits are numbered from the most significant end: index 0 is the top bit and index 63 the bottom bit. The window runs from a begin index to an end index. When begin is greater than end, the window wraps around the top of the word. A rotate with no masking uses begin 0 and end 63.

A word mode serves 32-bit operations. The low half of the source is copied into both halves. The copy is rotated by a 5-bit amount, and the window indices are moved into the low half by adding 32. The datapath is combinational. One output register, with a valid/ready handshake on each side, holds the result.

The input side takes an operand when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so with `out_ready` held high the unit takes one operand per cycle. While `out_valid` is high and `out_ready` is low, the result and `out_valid` stay frozen and `in_ready` stays low.

Top module: `rm_unit`

## Requirements
- R1: In doubleword mode (`in_word`=0), when begin ≤ end the mask has ones at indices begin through end inclusive (index 0 = bit 63 of the vector) and zeros elsewhere; begin 37, end 63 on an all-ones source with shift 0 gives 0x0000000007FFFFFF, and begin 0, end 10 gives 0xFFE0000000000000.
- R2: When begin > end the mask has ones from begin to 63 and from 0 to end; begin 47, end 37 gives 0xFFFFFFFFFC01FFFF, and begin 62, end 34 gives 0xFFFFFFFFE0000003.
- R3: Equal begin and end give a single one bit; 32/32 gives 0x0000000080000000 and 33/33 gives 0x0000000040000000.
- R4: In doubleword mode the result is the source rotated left by the 6-bit amount, ANDed with the mask; 0xDEADBEEF12345678 rotated by 10 with a full mask gives 0xB6FBBC48D159E37A, and rotated by 35 gives 0x91A2B3C6F56DF778.
- R5: In word mode (`in_word`=1) bits 31:0 of the source fill both halves of a 64-bit value, which is rotated left by bits 4:0 of the shift amount; bit 5 of the amount and source bits 63:32 have no effect. Low word 0xDEADBEEF rotated by 10 with begin 0 and end 31 gives 0x00000000B6FBBF7A, and rotated by 17 gives 0x000000007DDFBD5B.
- R6: In word mode the effective begin and end are 32 plus bits 4:0 of each index input; bit 5 of each index input has no effect.
- R7: An operand accepted at a rising edge appears on `out_data`, with `out_valid` high, right after the next rising edge, and results leave in the order they were accepted.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_valid` hold and `in_ready` is 0.
- R9: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero.
- R10: With no operand accepted, `out_data` keeps its last value, and `out_valid` falls after a rising edge at which `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_src | input | 64 | Source operand |
| in_shift | input | 6 | Left-rotate amount |
| in_begin | input | 6 | First mask index (MSB-first) |
| in_end | input | 6 | Last mask index (MSB-first) |
| in_word | input | 1 | 1 = 32-bit word mode, 0 = doubleword mode |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Rotated and masked result |

## Verification
An operand's result is due one rising edge after it is accepted. The result can arrive later only while the output side is stalled. The scoreboard records the cycle in which the driver saw each operand accepted. In phases where `out_ready` stays high, it requires the matching result exactly one cycle later, and in stalled phases it requires only that the order is kept. The stall, idle and reset checks sample just after a falling edge, so the register has settled from the previous rising edge.

// File: rtl/rm_pkg.sv
package rm_pkg;
  parameter int unsigned DATA_W  = 64;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned IDX_W  = $clog2(DATA_W);
  localparam int unsigned HIDX_W = $clog2(HALF_W);

  typedef enum logic {
    MODE_DWORD = 1'b0,
    MODE_WORD  = 1'b1
  } rm_mode_e;

  typedef struct packed {
    logic [DATA_W-1:0] value;
    logic [IDX_W-1:0]  amount;
    logic [IDX_W-1:0]  first;
    logic [IDX_W-1:0]  last;
  } rm_op_t;
endpackage

// File: rtl/rm_operand_prep.sv
module rm_operand_prep
  import rm_pkg::*;
(
  input  logic [DATA_W-1:0] src,
  input  logic [IDX_W-1:0]  shift,
  input  logic [IDX_W-1:0]  begin_idx,
  input  logic [IDX_W-1:0]  end_idx,
  input  rm_mode_e          mode,
  output rm_op_t            op
);
  // Word mode: replicate low half, keep only the half-width fields and
  // move the window into the low half by setting the top index bit.
  always_comb begin
    if (mode == MODE_WORD) begin
      op.value  = {src[HALF_W-1:0], src[HALF_W-1:0]};
      op.amount = {1'b0, shift[HIDX_W-1:0]};
      op.first  = {1'b1, begin_idx[HIDX_W-1:0]};
      op.last   = {1'b1, end_idx[HIDX_W-1:0]};
    end else begin
      op.value  = src;
      op.amount = shift;
      op.first  = begin_idx;
      op.last   = end_idx;
    end
  end
endmodule

// File: rtl/rm_rotator.sv
module rm_rotator
  import rm_pkg::*;
(
  input  logic [DATA_W-1:0] din,
  input  logic [IDX_W-1:0]  amount,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [IDX_W+1];

  assign stage[0] = din;

  // Logarithmic left rotator: stage k rotates by 2**k when amount[k] is set.
  for (genvar k = 0; k < IDX_W; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    always_comb begin
      if (amount[k])
        stage[k+1] = {stage[k][DATA_W-STEP-1:0], stage[k][DATA_W-1:DATA_W-STEP]};
      else
        stage[k+1] = stage[k];
    end
  end

  assign dout = stage[IDX_W];
endmodule

// File: rtl/rm_mask_gen.sv
module rm_mask_gen
  import rm_pkg::*;
(
  input  logic [IDX_W-1:0]  first,
  input  logic [IDX_W-1:0]  last,
  output logic [DATA_W-1:0] mask
);
  logic wraps;
  assign wraps = first > last;

  // Index i counts from the MSB, so it lands on vector bit DATA_W-1-i.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [IDX_W-1:0] POS = IDX_W'(i);
    logic ge_first, le_last;
    assign ge_first = POS >= first;
    assign le_last  = POS <= last;
    assign mask[DATA_W-1-i] = wraps ? (ge_first | le_last) : (ge_first & le_last);
  end
endmodule

// File: rtl/rm_unit.sv
module rm_unit
  import rm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_src,
  input  logic [IDX_W-1:0]  in_shift,
  input  logic [IDX_W-1:0]  in_begin,
  input  logic [IDX_W-1:0]  in_end,
  input  logic              in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  rm_op_t            op;
  logic [DATA_W-1:0] rotated;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] result;
  logic              accept;
  logic              vld_q;
  logic [DATA_W-1:0] data_q;

  rm_operand_prep u_prep (
    .src       (in_src),
    .shift     (in_shift),
    .begin_idx (in_begin),
    .end_idx   (in_end),
    .mode      (rm_mode_e'(in_word)),
    .op        (op)
  );

  rm_rotator u_rot (
    .din    (op.value),
    .amount (op.amount),
    .dout   (rotated)
  );

  rm_mask_gen u_mask (
    .first (op.first),
    .last  (op.last),
    .mask  (mask)
  );

  assign result   = rotated & mask;
  assign in_ready = ~vld_q | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      vld_q  <= 1'b1;
      data_q <= result;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;

  // A window always contains at least one index.
  p_mask_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (mask != '0));

  // Word-mode rotation of a replicated word keeps both halves equal.
  p_word_halves_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word) |-> (rotated[DATA_W-1:HALF_W] == rotated[HALF_W-1:0]));

  p_accept_latency_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_stall_noready_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!in_valid) |=> $stable(out_data));
endmodule

// File: tb/sim_rm_unit.sv
`timescale 1ns/1ps
module sim_rm_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_src = '0;
  logic [5:0]  in_shift = '0;
  logic [5:0]  in_begin = '0;
  logic [5:0]  in_end = '0;
  logic        in_word = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  always #2.5 clk = ~clk;

  rm_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_shift(in_shift), .in_begin(in_begin), .in_end(in_end),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit strict = 1'b1;
  bit done = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];
  int          cyc_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] src, input logic [5:0] sh,
                                         input logic [5:0] b, input logic [5:0] e,
                                         input logic word);
    logic [63:0] v, r, m;
    int s, bb, ee;
    v  = word ? {src[31:0], src[31:0]} : src;
    s  = word ? int'(sh[4:0]) : int'(sh);
    bb = word ? 32 + int'(b[4:0]) : int'(b);
    ee = word ? 32 + int'(e[4:0]) : int'(e);
    r  = v;
    for (int k = 0; k < s; k++) r = {r[62:0], r[63]};
    for (int i = 0; i < 64; i++)
      m[63-i] = (bb <= ee) ? (i >= bb && i <= ee) : (i >= bb || i <= ee);
    return r & m;
  endfunction

  task automatic send(input logic [63:0] src, input logic [5:0] sh, input logic [5:0] b,
                      input logic [5:0] e, input logic word, input logic [63:0] exp,
                      input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_src = src; in_shift = sh; in_begin = b; in_end = e; in_word = word;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(exp); tag_q.push_back(tag); cyc_q.push_back(cyc);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_m(input logic [63:0] src, input logic [5:0] sh, input logic [5:0] b,
                        input logic [5:0] e, input logic word, input string tag);
    send(src, sh, b, e, word, model(src, sh, b, e, word), tag);
  endtask

  // Monitor: pops one expected item per output handshake.
  always @(negedge clk) begin
    #1;
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected result", out_data, '0);
      end else begin
        logic [63:0] e;
        string t;
        int c;
        e = exp_q.pop_front(); t = tag_q.pop_front(); c = cyc_q.pop_front();
        check(out_data === e, t, out_data, e);
        if (strict)
          check(cyc == c + 1, "R7 latency", 64'(cyc), 64'(c + 1));
      end
    end
  end

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 1000) begin @(negedge clk); n++; end
    @(negedge clk); #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog", '0, '0);
    finish_run();
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    #1;
    // R9: reset state
    check(out_valid === 1'b0, "R9 reset valid", 64'(out_valid), 0);
    check(out_data === '0, "R9 reset data", out_data, 0);
    check(in_ready === 1'b1, "R9 ready after reset", 64'(in_ready), 1);
    @(negedge clk); rst = 1'b0;

    // Mask shapes on an all-ones source, no rotation
    send('1, 6'd0, 6'd37, 6'd63, 1'b0, 64'h0000000007FFFFFF, "R1 mask 37..63");
    send('1, 6'd0, 6'd0,  6'd10, 1'b0, 64'hFFE0000000000000, "R1 mask 0..10");
    send('1, 6'd0, 6'd47, 6'd37, 1'b0, 64'hFFFFFFFFFC01FFFF, "R2 wrap 47/37");
    send('1, 6'd0, 6'd62, 6'd34, 1'b0, 64'hFFFFFFFFE0000003, "R2 wrap 62/34");
    send('1, 6'd0, 6'd32, 6'd32, 1'b0, 64'h0000000080000000, "R3 single 32");
    send('1, 6'd0, 6'd33, 6'd33, 1'b0, 64'h0000000040000000, "R3 single 33");
    send('1, 6'd0, 6'd0,  6'd0,  1'b0, 64'h8000000000000000, "R3 single 0");
    send('1, 6'd0, 6'd63, 6'd63, 1'b0, 64'h0000000000000001, "R3 single 63");
    // 64-bit rotation
    send(64'hDEADBEEF12345678, 6'd10, 6'd0, 6'd63, 1'b0, 64'hB6FBBC48D159E37A, "R4 rot 10");
    send(64'hDEADBEEF12345678, 6'd35, 6'd0, 6'd63, 1'b0, 64'h91A2B3C6F56DF778, "R4 rot 35");
    send(64'hDEADBEEF12345678, 6'd0,  6'd0, 6'd63, 1'b0, 64'hDEADBEEF12345678, "R4 rot 0");
    send_m(64'hDEADBEEF12345678, 6'd63, 6'd5, 6'd50, 1'b0, "R4 rot 63 masked");
    // Word mode
    send(64'h12345678DEADBEEF, 6'd10, 6'd0, 6'd31, 1'b1, 64'h00000000B6FBBF7A, "R5 word rot 10");
    send(64'h12345678DEADBEEF, 6'd17, 6'd0, 6'd31, 1'b1, 64'h000000007DDFBD5B, "R5 word rot 17");
    send(64'hFFFFFFFFDEADBEEF, 6'd42, 6'd0, 6'd31, 1'b1, 64'h00000000B6FBBF7A, "R5 word shift bit5 ignored");
    send(64'h00000000DEADBEEF, 6'd10, 6'd32, 6'd63, 1'b1, 64'h00000000B6FBBF7A, "R6 word index bit5 ignored");
    send('1, 6'd0, 6'd0, 6'd0, 1'b1, 64'h0000000080000000, "R6 word single 0");
    send_m(64'h0123456789ABCDEF, 6'd7, 6'd20, 6'd4, 1'b1, "R6 word wrap");
    drain();

    // R10: idle keeps data, valid drops
    send(64'hDEADBEEF12345678, 6'd10, 6'd0, 6'd63, 1'b0, 64'hB6FBBC48D159E37A, "R10 last item");
    drain();
    repeat (2) @(negedge clk);
    #1;
    check(out_valid === 1'b0, "R10 valid dropped", 64'(out_valid), 0);
    check(out_data === 64'hB6FBBC48D159E37A, "R10 data held", out_data, 64'hB6FBBC48D159E37A);

    // R8: back-pressure
    strict = 1'b0;
    @(negedge clk); out_ready = 1'b0;
    send('1, 6'd0, 6'd0, 6'd3, 1'b0, 64'hF000000000000000, "R8 stalled item");
    @(negedge clk);
    in_valid = 1'b1; in_src = 64'h5555; in_shift = 6'd1; in_begin = 0; in_end = 63; in_word = 0;
    held = out_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(in_ready === 1'b0, "R8 ready low", 64'(in_ready), 0);
      check(out_valid === 1'b1 && out_data === held, "R8 hold", out_data, held);
    end
    in_valid = 1'b0;
    @(negedge clk); out_ready = 1'b1;
    drain();
    check(exp_q.size() == 0, "R8 stalled item delivered", 64'(exp_q.size()), 0);

    // Random traffic with random back-pressure
    fork
      begin
        for (int k = 0; k < 400; k++) begin
          @(negedge clk); out_ready = ($urandom_range(0, 3) != 0);
        end
        @(negedge clk); out_ready = 1'b1;
      end
      begin
        for (int k = 0; k < 300; k++) begin
          logic [63:0] s;
          logic [5:0] a, b, e;
          logic w;
          s = {$urandom, $urandom}; a = 6'($urandom); b = 6'($urandom);
          e = 6'($urandom); w = 1'($urandom);
          send_m(s, a, b, e, w, w ? "R5 R6 R7 random word" : "R1 R2 R4 R7 random dword");
        end
      end
    join
    drain();
    strict = 1'b1;

    // R9: reset mid-run with a result held
    @(negedge clk); out_ready = 1'b0;
    send('1, 6'd0, 6'd0, 6'd63, 1'b0, '1, "R9 pre-reset item");
    @(negedge clk); rst = 1'b1;
    void'(exp_q.pop_front()); void'(tag_q.pop_front()); void'(cyc_q.pop_front());
    @(negedge clk); #1;
    check(out_valid === 1'b0, "R9 mid-run valid cleared", 64'(out_valid), 0);
    check(out_data === '0, "R9 mid-run data cleared", out_data, 0);
    @(negedge clk); rst = 1'b0; out_ready = 1'b1;
    send('1, 6'd0, 6'd60, 6'd3, 1'b0, 64'hF00000000000000F, "R2 after reset");
    drain();
    check(exp_q.size() == 0, "R7 queue empty at end", 64'(exp_q.size()), 0);
    finish_run();
  end
endmodule